// File: doc/BRIEF.md
# Snooping Write-Back Coherence Controller for a Direct-Mapped Cache

This block keeps the coherence state and tag of every line of a small direct-mapped cache that sits on a shared snooping bus next to other caches. Each line is held in one of four states: invalid, shared, exclusive or modified. A processor port accepts read and write requests and answers with a ready strobe and a hit flag. A bus port issues this cache's own transactions (read, read-for-ownership, invalidate, writeback), one at a time, under control of an external arbiter. A snoop port watches other caches' transactions and answers in the same cycle with a shared flag and a dirty-intervention flag.

Addresses are line-granular. The low `IDX_W` bits select the line and the upper bits form the tag. A granted bus transaction completes in its grant cycle. When the snooper holds a modified line that another cache reads or claims, its intervention supplies the data within that same transaction, so memory is brought up to date there and then. A request that needs the bus is retried inside the block once the fill or upgrade completes. The processor holds its request until it sees ready.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is invalid. The first access to any address misses, and a snooped read of any address raises neither snoop flag.
- R2: A read miss issues a read (bus_cmd 0) at the request address. If bus_shared_in is low in the grant cycle the line is installed exclusive, otherwise shared. The request then completes with cpu_hit low.
- R3: A read that hits a shared, exclusive or modified line completes with cpu_ready and cpu_hit high in the cycle the request is first presented. It raises no bus request and does not change the line's state.
- R4: A write that hits a shared line issues an invalidate (bus_cmd 2) at the request address, leaves the line modified and completes with cpu_hit low.
- R5: A write that hits an exclusive or modified line completes at once with cpu_hit high and no bus request, and leaves the line modified.
- R6: A snooped read (snp_cmd 0) that hits a valid line raises snp_shared in the same cycle and leaves the line shared.
- R7: A snooped read that hits a modified line also raises snp_dirty, and the line becomes shared.
- R8: A snooped read-for-ownership (1) or invalidate (2) that hits a valid line leaves it invalid and raises snp_dirty if the line was modified. A snooped writeback (3) or a snoop that misses changes nothing.
- R9: A miss whose victim line is modified first issues a writeback (bus_cmd 3) at the victim's own address, and then the fetch. A clean victim is replaced without any writeback.
- R10: A write miss issues a read-for-ownership (bus_cmd 1) at the request address and installs the line modified.
- R11: Only one bus transaction is outstanding at a time. A read, read-for-ownership or invalidate request stays asserted at a fixed address until bus_grant.
- R12: A snoop to the index of the presented processor request takes priority and withholds cpu_ready for that cycle. If a snoop removes a shared line while its upgrade waits for the bus, the pending request becomes a read-for-ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | AW | Line address of the request |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Completed request needed no bus transaction |
| bus_req | output | 1 | Own bus transaction requested |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_addr | output | AW | Line address of own transaction |
| bus_gnt | input | 1 | Own transaction granted and completed this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (sampled with grant) |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction, same coding |
| snp_addr | input | AW | Line address of the snooped transaction |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_dirty | output | 1 | This cache intervenes with modified data |

## Verification
On every cycle the assertions check that an own request is held at a stable address until grant, that a fetch is never issued over a modified victim, that an invalidate is only issued for a line still held shared, and that each snoop update lands in the addressed line with no clash against a processor-side update. The state sequences themselves can only be shown by the bench's scenarios. These are exclusive versus shared fills, silent upgrades, intervention followed by a shared state, writeback ordering on conflict misses, and an upgrade that turns into a read-for-ownership after its line is snooped away. The bench shows each of them through later bus traffic and snoop answers, compared with its own model of every line.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_READ = 2'd0,
    BC_RDX  = 2'd1,
    BC_INV  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_WBACK = 2'd1,
    CS_FETCH = 2'd2,
    CS_UPGR  = 2'd3
  } ctl_st_e;
endpackage

// File: rtl/coh_tag_store.sv
`timescale 1ns/1ps
module coh_tag_store
  import coh_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output line_st_e         a_st,
  output logic [TAG_W-1:0] a_tag,
  input  logic [IDX_W-1:0] b_idx,
  output line_st_e         b_st,
  output logic [TAG_W-1:0] b_tag,
  input  logic             s_we,
  input  line_st_e         s_st,
  input  logic             c_we,
  input  line_st_e         c_st,
  input  logic [TAG_W-1:0] c_tag
);
  localparam int LINES = 1 << IDX_W;

  line_st_e         st_all  [LINES];
  logic [TAG_W-1:0] tag_all [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e         st_q, st_d;
    logic [TAG_W-1:0] tag_q;
    logic             sel_s, sel_c;

    assign sel_s = s_we && (b_idx == IDX_W'(g));
    assign sel_c = c_we && (a_idx == IDX_W'(g));

    always_comb begin
      st_d = st_q;
      if (sel_s)      st_d = s_st;
      else if (sel_c) st_d = c_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= LS_INV;
        tag_q <= '0;
      end else begin
        if (sel_s || sel_c) st_q <= st_d;
        if (sel_c && !sel_s) tag_q <= c_tag;
      end
    end

    assign st_all[g]  = st_q;
    assign tag_all[g] = tag_q;
  end

  assign a_st  = st_all[a_idx];
  assign a_tag = tag_all[a_idx];
  assign b_st  = st_all[b_idx];
  assign b_tag = tag_all[b_idx];

  // R8 / R6: a snoop-driven update is visible in the addressed line next cycle
  assert_snoop_update_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_we |=> st_all[$past(b_idx)] == $past(s_st));

  // R12: processor-side and snoop-side updates never target one line together
  assert_no_update_clash_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_we && c_we && (a_idx == b_idx)));
endmodule

// File: rtl/coh_snoop_resp.sv
`timescale 1ns/1ps
module coh_snoop_resp
  import coh_pkg::*;
#(
  parameter int TAG_W = 9
) (
  input  logic             snp_valid,
  input  bus_cmd_e         snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_e         line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             snp_shared,
  output logic             snp_dirty,
  output logic             upd_we,
  output line_st_e         upd_st
);
  logic present;

  assign present = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);

  always_comb begin
    snp_shared = 1'b0;
    snp_dirty  = 1'b0;
    upd_we     = 1'b0;
    upd_st     = line_st;
    unique case (snp_cmd)
      BC_READ: begin
        snp_shared = present;
        snp_dirty  = present && (line_st == LS_MOD);
        upd_we     = present;
        upd_st     = LS_SHR;
      end
      BC_RDX, BC_INV: begin
        snp_dirty = present && (line_st == LS_MOD);
        upd_we    = present;
        upd_st    = LS_INV;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_miss_fsm.sv
`timescale 1ns/1ps
module coh_miss_fsm
  import coh_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9,
  localparam int AW   = IDX_W + TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic             snp_block,
  output logic             cpu_ready,
  output logic             cpu_hit,
  output logic             bus_req,
  output bus_cmd_e         bus_cmd,
  output logic [AW-1:0]    bus_addr,
  input  logic             bus_gnt,
  input  logic             bus_shared_in,
  output logic [IDX_W-1:0] look_idx,
  input  line_st_e         line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             c_we,
  output line_st_e         c_st,
  output logic [TAG_W-1:0] c_tag
);
  ctl_st_e          cs_q, cs_d;
  logic [AW-1:0]    ra_q;
  logic             rw_q;
  logic             ub_q, ub_d;
  logic             ld_req;
  logic [AW-1:0]    cur_addr;
  logic [TAG_W-1:0] cur_tag;
  logic             match;

  assign cur_addr = (cs_q == CS_IDLE) ? cpu_addr : ra_q;
  assign cur_tag  = cur_addr[AW-1:IDX_W];
  assign look_idx = cur_addr[IDX_W-1:0];
  assign match    = (line_st != LS_INV) && (line_tag == cur_tag);

  always_comb begin
    cs_d      = cs_q;
    ub_d      = ub_q;
    ld_req    = 1'b0;
    cpu_ready = 1'b0;
    cpu_hit   = 1'b0;
    bus_req   = 1'b0;
    bus_cmd   = BC_READ;
    bus_addr  = ra_q;
    c_we      = 1'b0;
    c_st      = LS_MOD;
    c_tag     = cur_tag;
    unique case (cs_q)
      CS_IDLE: begin
        if (cpu_req && !snp_block) begin
          if (match && (!cpu_we || line_st != LS_SHR)) begin
            cpu_ready = 1'b1;
            cpu_hit   = !ub_q;
            ub_d      = 1'b0;
            if (cpu_we && line_st == LS_EXC) c_we = 1'b1;
          end else begin
            ld_req = 1'b1;
            if (match)                  cs_d = CS_UPGR;
            else if (line_st == LS_MOD) cs_d = CS_WBACK;
            else                        cs_d = CS_FETCH;
          end
        end
      end
      CS_WBACK: begin
        if (line_st == LS_MOD) begin
          bus_req  = 1'b1;
          bus_cmd  = BC_WB;
          bus_addr = {line_tag, look_idx};
          if (bus_gnt) begin
            c_we  = 1'b1;
            c_st  = LS_INV;
            c_tag = line_tag;
            ub_d  = 1'b1;
            cs_d  = CS_FETCH;
          end
        end else begin
          cs_d = CS_FETCH;
        end
      end
      CS_FETCH: begin
        bus_req = 1'b1;
        bus_cmd = rw_q ? BC_RDX : BC_READ;
        if (bus_gnt) begin
          c_we = 1'b1;
          c_st = rw_q ? LS_MOD : (bus_shared_in ? LS_SHR : LS_EXC);
          ub_d = 1'b1;
          cs_d = CS_IDLE;
        end
      end
      CS_UPGR: begin
        bus_req = 1'b1;
        bus_cmd = match ? BC_INV : BC_RDX;
        if (bus_gnt) begin
          c_we = 1'b1;
          ub_d = 1'b1;
          cs_d = CS_IDLE;
        end
      end
      default: cs_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= CS_IDLE;
      ra_q <= '0;
      rw_q <= 1'b0;
      ub_q <= 1'b0;
    end else begin
      cs_q <= cs_d;
      ub_q <= ub_d;
      if (ld_req) begin
        ra_q <= cpu_addr;
        rw_q <= cpu_we;
      end
    end
  end

  // R11: a pending fetch or upgrade holds its request and address until grant
  assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && bus_cmd != BC_WB) |=> (bus_req && $stable(bus_addr)));

  // R9: a fetch never goes out while a modified line of another tag occupies the slot
  assert_no_dirty_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && (bus_cmd == BC_READ || bus_cmd == BC_RDX))
      |-> !(line_st == LS_MOD && line_tag != ra_q[AW-1:IDX_W]));

  // R4: an invalidate is only issued while the own copy is still shared
  assert_upgrade_from_shared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == BC_INV)
      |-> (line_st == LS_SHR && line_tag == ra_q[AW-1:IDX_W]));
endmodule

// File: rtl/coh_line_ctrl.sv
`timescale 1ns/1ps
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int AW    = 12,
  parameter int IDX_W = 3,
  localparam int TAG_W = AW - IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_ready,
  output logic          cpu_hit,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_gnt,
  input  logic          bus_shared_in,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared,
  output logic          snp_dirty
);
  logic [1:0]       rs_q;
  logic             rst_n_int;
  logic [IDX_W-1:0] look_idx;
  line_st_e         a_st, b_st, c_st, s_st;
  logic [TAG_W-1:0] a_tag, b_tag, c_tag;
  logic             c_we, s_we, snp_block;
  bus_cmd_e         fsm_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_int = rs_q[1];

  assign snp_block = snp_valid && (snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);
  assign bus_cmd   = fsm_cmd;

  coh_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) store_i (
    .clk   (clk),
    .rst_n (rst_n_int),
    .a_idx (look_idx),
    .a_st  (a_st),
    .a_tag (a_tag),
    .b_idx (snp_addr[IDX_W-1:0]),
    .b_st  (b_st),
    .b_tag (b_tag),
    .s_we  (s_we),
    .s_st  (s_st),
    .c_we  (c_we),
    .c_st  (c_st),
    .c_tag (c_tag)
  );

  coh_snoop_resp #(.TAG_W(TAG_W)) snoop_i (
    .snp_valid  (snp_valid),
    .snp_cmd    (bus_cmd_e'(snp_cmd)),
    .snp_tag    (snp_addr[AW-1:IDX_W]),
    .line_st    (b_st),
    .line_tag   (b_tag),
    .snp_shared (snp_shared),
    .snp_dirty  (snp_dirty),
    .upd_we     (s_we),
    .upd_st     (s_st)
  );

  coh_miss_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W)) fsm_i (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .cpu_addr      (cpu_addr),
    .snp_block     (snp_block),
    .cpu_ready     (cpu_ready),
    .cpu_hit       (cpu_hit),
    .bus_req       (bus_req),
    .bus_cmd       (fsm_cmd),
    .bus_addr      (bus_addr),
    .bus_gnt       (bus_gnt),
    .bus_shared_in (bus_shared_in),
    .look_idx      (look_idx),
    .line_st       (a_st),
    .line_tag      (a_tag),
    .c_we          (c_we),
    .c_st          (c_st),
    .c_tag         (c_tag)
  );
endmodule

// File: tb/coh_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module coh_line_ctrl_tb_top;
  localparam int AW = 12;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic          cpu_ready, cpu_hit;
  logic          bus_req;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic          bus_gnt, bus_shared_in;
  logic          snp_valid;
  logic [1:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic          snp_shared, snp_dirty;

  int checks = 0;
  int errors = 0;
  int mst [8];
  int mtg [8];

  always #2.5 clk = ~clk;

  coh_line_ctrl #(.AW(AW), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_dirty(snp_dirty)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int mk_addr(input int tag, input int idx);
    return tag * 8 + idx;
  endfunction

  task automatic cpu_op(input bit we, input int tag, input int idx, input int shr);
    int ecmd[2];
    int eaddr[2];
    int ne = 0;
    int got = 0;
    int dly;
    int last_shr = 0;
    bit ehit = 0;
    bit held = 0;
    bit done = 0;
    bit hitm;
    bit fill = 0;
    string rq;
    hitm = (mst[idx] != 0) && (mtg[idx] == tag);
    if (hitm && (!we || mst[idx] != 1)) begin
      ehit = 1; rq = we ? "R5" : "R3";
    end else if (hitm) begin
      ecmd[0] = 2; eaddr[0] = mk_addr(tag, idx); ne = 1; rq = "R4";
    end else begin
      fill = 1;
      rq = we ? "R10" : "R2";
      if (mst[idx] == 3) begin
        ecmd[0] = 3; eaddr[0] = mk_addr(mtg[idx], idx); ne = 1; rq = "R9";
      end
      ecmd[ne] = we ? 1 : 0; eaddr[ne] = mk_addr(tag, idx); ne++;
    end
    dly = $urandom % 3;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(mk_addr(tag, idx));
    for (int cyc = 0; cyc < 40; cyc++) begin
      #1;
      if (held) chk(bus_req == 1'b1, "R11", "request held until grant", int'(bus_req), 1);
      held = 0;
      if (cpu_ready) begin
        chk(got == ne, rq, "bus transactions before ready", got, ne);
        chk(cpu_hit == ehit, rq, "cpu_hit", int'(cpu_hit), int'(ehit));
        if (ehit) chk(bus_req == 1'b0, rq, "no bus request on hit", int'(bus_req), 0);
        done = 1;
        break;
      end
      if (bus_req) begin
        if (got >= ne) begin
          chk(1'b0, rq, "unexpected bus command", int'(bus_cmd), -1);
          bus_gnt = 1'b1;
        end else if (dly > 0) begin
          dly--; held = 1;
        end else begin
          chk(int'(bus_cmd) == ecmd[got], rq, "bus_cmd", int'(bus_cmd), ecmd[got]);
          chk(int'(bus_addr) == eaddr[got], rq, "bus_addr", int'(bus_addr), eaddr[got]);
          last_shr = (shr < 0) ? int'($urandom % 2) : shr;
          bus_gnt = 1'b1;
          bus_shared_in = last_shr[0];
          got++;
          dly = $urandom % 3;
        end
      end
      @(negedge clk);
      bus_gnt = 1'b0; bus_shared_in = 1'b0;
    end
    if (!done) chk(1'b0, rq, "request never completed", 0, 1);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (ehit) begin
      if (we) mst[idx] = 3;
    end else if (!fill) begin
      mst[idx] = 3;
    end else begin
      mst[idx] = we ? 3 : (last_shr != 0 ? 1 : 2);
      mtg[idx] = tag;
    end
  endtask

  task automatic snoop(input int cmd, input int tag, input int idx);
    bit hit;
    bit eshr;
    bit edty;
    string rq;
    hit  = (mst[idx] != 0) && (mtg[idx] == tag);
    eshr = hit && (cmd == 0);
    edty = hit && (mst[idx] == 3) && (cmd != 3);
    if (cmd == 0) rq = (mst[idx] == 3) ? "R7" : "R6";
    else          rq = "R8";
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = AW'(mk_addr(tag, idx));
    #1;
    chk(snp_shared == eshr, rq, "snp_shared", int'(snp_shared), int'(eshr));
    chk(snp_dirty == edty, rq, "snp_dirty", int'(snp_dirty), int'(edty));
    @(negedge clk);
    snp_valid = 1'b0;
    if (hit) begin
      if (cmd == 0) mst[idx] = 1;
      else if (cmd != 3) mst[idx] = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin mst[i] = 0; mtg[i] = 0; end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0;
    bus_gnt = 1'b0; bus_shared_in = 1'b0;
    snp_valid = 1'b0; snp_cmd = '0; snp_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(cpu_ready == 1'b0 && bus_req == 1'b0, "R1", "idle outputs after reset",
        int'({cpu_ready, bus_req}), 0);
    // R1: every line invalid, so snooped reads find nothing
    for (int i = 0; i < 8; i++) snoop(0, 0, i);

    // main state walk on one line
    cpu_op(0, 0, 0, 0);   // R2 exclusive fill
    cpu_op(0, 0, 0, -1);  // R3 read hit
    cpu_op(1, 0, 0, -1);  // R5 silent upgrade
    snoop(0, 0, 0);       // R7 intervention, now shared
    cpu_op(0, 0, 0, -1);  // R3 hit in shared
    cpu_op(1, 0, 0, -1);  // R4 invalidate
    snoop(1, 0, 0);       // R8 dirty, now invalid
    cpu_op(0, 0, 0, 1);   // R2 shared fill
    snoop(3, 0, 0);       // R8 writeback snoop ignored
    snoop(0, 0, 0);       // R6 shared stays shared
    cpu_op(0, 0, 0, -1);  // R3 still present

    // conflict misses
    cpu_op(1, 1, 1, -1);  // R10
    cpu_op(0, 2, 1, 0);   // R9 writeback of tag 1 first
    cpu_op(0, 3, 1, 0);   // R9 clean victim, silent
    snoop(2, 3, 1);       // R8 invalidate clean line
    cpu_op(0, 3, 1, 1);   // R2 refetch

    // R12: snoop on the presented index withholds ready
    cpu_op(0, 0, 3, 0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(mk_addr(0, 3));
    snp_valid = 1'b1; snp_cmd = 2'd0; snp_addr = AW'(mk_addr(2, 3));
    #1;
    chk(cpu_ready == 1'b0, "R12", "ready withheld during same-index snoop", int'(cpu_ready), 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(cpu_ready == 1'b1 && cpu_hit == 1'b1, "R12", "hit after snoop cycle",
        int'({cpu_ready, cpu_hit}), 3);
    @(negedge clk);
    cpu_req = 1'b0;

    // R12: shared line snooped away while its upgrade waits
    cpu_op(0, 0, 2, 1);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(mk_addr(0, 2));
    #1;
    chk(cpu_ready == 1'b0, "R4", "write to shared does not complete at once", int'(cpu_ready), 0);
    @(negedge clk);
    #1;
    chk(bus_req == 1'b1 && bus_cmd == 2'd2, "R4", "invalidate pending",
        int'({bus_req, bus_cmd}), 6);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = AW'(mk_addr(0, 2));
    #1;
    chk(snp_dirty == 1'b0 && snp_shared == 1'b0, "R12", "snoop of shared line flags",
        int'({snp_dirty, snp_shared}), 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(bus_req == 1'b1 && bus_cmd == 2'd1, "R12", "upgrade turned read-for-ownership",
        int'({bus_req, bus_cmd}), 5);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    #1;
    chk(cpu_ready == 1'b1 && cpu_hit == 1'b0, "R12", "write completes after ownership",
        int'({cpu_ready, cpu_hit}), 2);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    mst[2] = 3; mtg[2] = 0;
    snoop(0, 0, 2);       // R7 line is modified

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 6) cpu_op(1'($urandom % 2), int'($urandom % 4), int'($urandom % 8), -1);
      else       snoop(int'($urandom % 4), int'($urandom % 4), int'($urandom % 8));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule